// File: doc/BRIEF.md
# Weighted Memory-Command Activity Filter

This block watches the memory command bus on every clock and sorts the cycle into one of four classes: read, write, other command (precharge, refresh, activate and the like), or idle. Each class has its own programmable 8-bit weight. The weight chosen for the cycle goes into an exponential moving-average filter. The filter output is a smoothed estimate of bus activity, which throttling logic downstream compares against its limits.

One 32-bit register holds all four weights, and a lock input can freeze it. When the bus runs at a two-clock command rate, the other-command weight is stored at half scale and doubled on use. A stored value above 7Fh is then out of range and raises a configuration-error flag. A second register holds a 16-bit threshold. A registered flag reports when the filter output is above that threshold.

Top module: `actflt_top`

## Requirements
- R1: While reset is asserted, and for two clocks after it is released, `activity`, `over_threshold` and `cfg_error` are 0 and every weight field reads as 00h.
- R2: In a clock where `cmd_rd` is high, the filter input is the read weight (bits 31:24 of the weight register). This holds even if `cmd_wr` or `cmd_oth` is also high.
- R3: In a clock where `cmd_wr` is high and `cmd_rd` is low, the filter input is the write weight (bits 23:16). This holds even if `cmd_oth` is also high.
- R4: In a clock where only `cmd_oth` is high, the filter input is the other-command weight (bits 15:8). When `rate_2n` is high it is twice the stored value, saturating at FFh.
- R5: In a clock with no command, the filter input is the idle weight (bits 7:0). If `bus_tristate` is also high, the filter input is 0.
- R6: `cfg_error` is high exactly when `rate_2n` is high and the stored other-command weight is greater than 7Fh.
- R7: A write to address 0 while `cfg_lock` is high leaves all four weights unchanged. A write to address 1 still updates the threshold.
- R8: On each clock, `activity` (16 bits, 8 fractional) becomes avg + ((in·256 − avg) >> 4). The shift is arithmetic, the operands are signed, and `in` is the filter input of that clock.
- R9: `over_threshold` becomes (activity > threshold) one clock after that `activity` value appears.
- R10: When `reg_wr_en` is high, address 0 writes the weights from `reg_wr_data[31:0]` if unlocked, and address 1 writes the threshold from `reg_wr_data[15:0]`. Writes to addresses 2 and 3 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 weights, 1 threshold |
| reg_wr_data | input | 32 | Register write data |
| cfg_lock | input | 1 | Freezes the weight register |
| cmd_rd | input | 1 | Valid read command this clock |
| cmd_wr | input | 1 | Valid write command this clock |
| cmd_oth | input | 1 | Valid command that is neither read nor write |
| bus_tristate | input | 1 | Command and address lines are floated |
| rate_2n | input | 1 | Two-clock command-rate mode |
| activity | output | 16 | Filtered activity estimate, 8.8 fixed point |
| over_threshold | output | 1 | Registered activity-above-threshold flag |
| cfg_error | output | 1 | Other-command weight out of range for 2N mode |

## Verification
On every cycle, the assertions check that a read cycle selects the read field, that a floated idle bus feeds zero, that the range error tracks the mode and the stored field, that a locked weight write leaves the weights stable, that the average moves toward its input, and that it never passes its ceiling. The bench scenarios are the only evidence for the exact arithmetic of the filter steps, the doubling and saturation in 2N mode, threshold writes while the lock is held, writes to unused addresses, and the one-clock lag of the threshold flag. A behavioural model predicts each of these, and the bench compares against it on every clock.

// File: rtl/actflt_pkg.sv
package actflt_pkg;
  localparam int WGT_W  = 8;
  localparam int NUM_W  = 4;
  localparam int REG_W  = WGT_W * NUM_W;
  localparam int ACC_W  = 16;
  localparam int FRAC_W = 8;
  localparam int SHIFT  = 4;
  localparam int THR_W  = 16;
  localparam int ADDR_W = 2;

  typedef enum logic [1:0] {
    CLS_IDLE = 2'd0,
    CLS_RD   = 2'd1,
    CLS_WR   = 2'd2,
    CLS_OTH  = 2'd3
  } cmd_cls_e;

  // field order follows the register bit layout, read weight in the top byte
  typedef struct packed {
    logic [WGT_W-1:0] rd;
    logic [WGT_W-1:0] wr;
    logic [WGT_W-1:0] oth;
    logic [WGT_W-1:0] idle;
  } wgt_set_t;
endpackage

// File: rtl/actflt_regs.sv
module actflt_regs
  import actflt_pkg::*;
#(
  parameter int AW       = ADDR_W,
  parameter int TW       = THR_W,
  parameter int WGT_ADDR = 0,
  parameter int THR_ADDR = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [REG_W-1:0] wdata,
  input  logic          lock,
  output wgt_set_t      weights,
  output logic [TW-1:0] thr
);
  wgt_set_t      wgt_q, wgt_d;
  logic [TW-1:0] thr_q, thr_d;
  logic          wgt_en, thr_en;

  always_comb begin
    wgt_en = wr_en && (addr == AW'(WGT_ADDR)) && !lock;
    thr_en = wr_en && (addr == AW'(THR_ADDR));
    wgt_d  = wgt_q;
    thr_d  = thr_q;
    if (wgt_en) wgt_d = wgt_set_t'(wdata);
    if (thr_en) thr_d = wdata[TW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wgt_q <= '0;
      thr_q <= '0;
    end else begin
      if (wgt_en) wgt_q <= wgt_d;
      if (thr_en) thr_q <= thr_d;
    end
  end

  assign weights = wgt_q;
  assign thr     = thr_q;

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && wr_en && addr == AW'(WGT_ADDR)) |=> $stable(weights));
endmodule

// File: rtl/actflt_classify.sv
module actflt_classify
  import actflt_pkg::*;
(
  input  wgt_set_t         weights,
  input  logic             cmd_rd,
  input  logic             cmd_wr,
  input  logic             cmd_oth,
  input  logic             bus_tristate,
  input  logic             rate_2n,
  output cmd_cls_e         cls,
  output logic [WGT_W-1:0] filt_in,
  output logic             cfg_err
);
  localparam int HALF_MAX = (1 << (WGT_W - 1)) - 1;

  logic [WGT_W:0]   oth_dbl;
  logic [WGT_W-1:0] oth_eff;

  always_comb begin
    if (cmd_rd)       cls = CLS_RD;
    else if (cmd_wr)  cls = CLS_WR;
    else if (cmd_oth) cls = CLS_OTH;
    else              cls = CLS_IDLE;
  end

  always_comb begin
    oth_dbl = {weights.oth, 1'b0};
    if (!rate_2n)       oth_eff = weights.oth;
    else if (oth_dbl[WGT_W]) oth_eff = '1;
    else                oth_eff = oth_dbl[WGT_W-1:0];
  end

  always_comb begin
    unique case (cls)
      CLS_RD:  filt_in = weights.rd;
      CLS_WR:  filt_in = weights.wr;
      CLS_OTH: filt_in = oth_eff;
      default: filt_in = bus_tristate ? '0 : weights.idle;
    endcase
  end

  assign cfg_err = rate_2n && (weights.oth > WGT_W'(HALF_MAX));
endmodule

// File: rtl/actflt_ema.sv
module actflt_ema
  import actflt_pkg::*;
#(
  parameter int IN_W = WGT_W,
  parameter int AW   = ACC_W,
  parameter int FW   = FRAC_W,
  parameter int SH   = SHIFT
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IN_W-1:0] in_w,
  output logic [AW-1:0]   avg
);
  localparam int EXT_W = AW + 2;
  localparam logic [AW-1:0] CEIL = AW'(((1 << IN_W) - 1) << FW);

  logic [AW-1:0]           avg_q, avg_d;
  logic [EXT_W-1:0]        tgt_u;
  logic signed [EXT_W-1:0] diff, step, sum;

  always_comb begin
    tgt_u = EXT_W'(in_w) << FW;
    diff  = $signed(tgt_u) - $signed(EXT_W'(avg_q));
    step  = diff >>> SH;
    sum   = $signed(EXT_W'(avg_q)) + step;
    avg_d = sum[AW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) avg_q <= '0;
    else        avg_q <= avg_d;
  end

  assign avg = avg_q;

  // R8
  ema_ceiling_chk: assert property (@(posedge clk) disable iff (!rst_n)
    avg_q <= CEIL);

  // R8
  ema_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_u > EXT_W'(avg_q)) |=> (avg_q >= $past(avg_q)));
endmodule

// File: rtl/actflt_top.sv
module actflt_top
  import actflt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic              cfg_lock,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic              cmd_oth,
  input  logic              bus_tristate,
  input  logic              rate_2n,
  output logic [ACC_W-1:0]  activity,
  output logic              over_threshold,
  output logic              cfg_error
);
  logic             rst_meta, rst_sync;
  wgt_set_t         weights;
  logic [THR_W-1:0] thr;
  cmd_cls_e         cls;
  logic [WGT_W-1:0] filt_in;
  logic             over_q, over_d;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  actflt_regs u_regs (
    .clk     (clk),
    .rst_n   (rst_sync),
    .wr_en   (reg_wr_en),
    .addr    (reg_addr),
    .wdata   (reg_wr_data),
    .lock    (cfg_lock),
    .weights (weights),
    .thr     (thr)
  );

  actflt_classify u_cls (
    .weights      (weights),
    .cmd_rd       (cmd_rd),
    .cmd_wr       (cmd_wr),
    .cmd_oth      (cmd_oth),
    .bus_tristate (bus_tristate),
    .rate_2n      (rate_2n),
    .cls          (cls),
    .filt_in      (filt_in),
    .cfg_err      (cfg_error)
  );

  actflt_ema u_ema (
    .clk   (clk),
    .rst_n (rst_sync),
    .in_w  (filt_in),
    .avg   (activity)
  );

  always_comb over_d = (activity > thr);

  always_ff @(posedge clk or negedge rst_sync) begin
    if (!rst_sync) over_q <= 1'b0;
    else           over_q <= over_d;
  end

  assign over_threshold = over_q;

  // R2
  rd_select_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    cmd_rd |-> (cls == CLS_RD && filt_in == weights.rd));

  // R5
  tristate_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (bus_tristate && !cmd_rd && !cmd_wr && !cmd_oth) |-> (filt_in == '0));

  // R6
  range_err_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (rate_2n && weights.oth[WGT_W-1]) |-> cfg_error);

  // R9
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (activity <= thr) |=> !over_threshold);
endmodule

// File: tb/actflt_top_tb.sv
module actflt_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wr_data = '0;
  logic        cfg_lock = 1'b0;
  logic        cmd_rd = 1'b0, cmd_wr = 1'b0, cmd_oth = 1'b0;
  logic        bus_tristate = 1'b0, rate_2n = 1'b0;
  logic [15:0] activity;
  logic        over_threshold, cfg_error;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_rd, m_wr, m_oth, m_idle, m_thr, m_avg;
  bit m_over, m_s1, m_s2;

  always #5 clk = ~clk;

  actflt_top u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wr_data(reg_wr_data), .cfg_lock(cfg_lock), .cmd_rd(cmd_rd),
    .cmd_wr(cmd_wr), .cmd_oth(cmd_oth), .bus_tristate(bus_tristate),
    .rate_2n(rate_2n), .activity(activity), .over_threshold(over_threshold),
    .cfg_error(cfg_error)
  );

  function automatic int model_in();
    int e;
    if (cmd_rd) return m_rd;
    if (cmd_wr) return m_wr;
    if (cmd_oth) begin
      e = rate_2n ? m_oth * 2 : m_oth;
      return (e > 255) ? 255 : e;
    end
    return bus_tristate ? 0 : m_idle;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_rd = 0; m_wr = 0; m_oth = 0; m_idle = 0; m_thr = 0;
      m_avg = 0; m_over = 0; m_s1 = 0; m_s2 = 0;
    end else begin
      if (m_s2) begin
        int inp, nxt_over;
        inp = model_in();
        nxt_over = (m_avg > m_thr);
        m_avg = m_avg + ((inp * 256 - m_avg) >>> 4);
        m_over = nxt_over[0];
        if (reg_wr_en && reg_addr == 2'd0 && !cfg_lock) begin
          m_rd = reg_wr_data[31:24]; m_wr = reg_wr_data[23:16];
          m_oth = reg_wr_data[15:8]; m_idle = reg_wr_data[7:0];
        end
        if (reg_wr_en && reg_addr == 2'd1) m_thr = reg_wr_data[15:0];
      end
      m_s2 = m_s1;
      m_s1 = 1'b1;
    end
  end

  always @(negedge clk) begin
    cycles++;
    checks++;
    if (int'(activity) != m_avg) begin
      fails++;
      $display("FAIL %s/R8 activity actual=%h expected=%h t=%0t", cur_req, activity, m_avg, $time);
    end
    checks++;
    if (over_threshold != m_over) begin
      fails++;
      $display("FAIL R9 over_threshold actual=%b expected=%b t=%0t", over_threshold, m_over, $time);
    end
    checks++;
    if (cfg_error != (rate_2n && m_oth > 127)) begin
      fails++;
      $display("FAIL R6 cfg_error actual=%b expected=%b t=%0t", cfg_error, rate_2n && m_oth > 127, $time);
    end
  end

  task automatic finish_up();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=%0d expected<100000 cycles", cycles);
    finish_up();
  end

  task automatic drive(input bit rd, input bit wr, input bit oth, input bit ts, input int n);
    @(posedge clk); #1;
    cmd_rd = rd; cmd_wr = wr; cmd_oth = oth; bus_tristate = ts;
    repeat (n - 1) @(posedge clk);
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(posedge clk); #1;
    reg_wr_en = 1'b1; reg_addr = a; reg_wr_data = d;
    @(posedge clk); #1;
    reg_wr_en = 1'b0;
  endtask

  initial begin
    // R1: reset state, including writes attempted during reset
    cur_req = "R1";
    reg_wr_en = 1'b1; reg_wr_data = 32'hFFFF_FFFF; cmd_rd = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1 reg_wr_en = 1'b0; cmd_rd = 1'b0;
    repeat (3) @(posedge clk);

    // R10: program weights and threshold
    cur_req = "R10";
    wr_reg(2'd0, 32'h40_20_90_08);
    wr_reg(2'd1, 32'hABCD_0300);

    cur_req = "R5";
    drive(0, 0, 0, 0, 40);
    drive(0, 0, 0, 1, 20);

    cur_req = "R2";
    drive(1, 0, 0, 0, 30);
    drive(1, 1, 1, 0, 10);

    cur_req = "R3";
    drive(0, 1, 0, 0, 30);
    drive(0, 1, 1, 1, 10);

    cur_req = "R4";
    drive(0, 0, 1, 0, 20);
    rate_2n = 1'b1;
    drive(0, 0, 1, 0, 20);
    cur_req = "R6";
    wr_reg(2'd0, 32'h40_20_7F_08);
    drive(0, 0, 1, 0, 10);
    wr_reg(2'd0, 32'h40_20_80_08);
    drive(0, 0, 1, 0, 10);
    cur_req = "R4";
    wr_reg(2'd0, 32'h40_20_60_08);
    drive(0, 0, 1, 0, 30);
    rate_2n = 1'b0;
    drive(0, 0, 1, 0, 10);

    // R7: locked weight write ignored, threshold still writable
    cur_req = "R7";
    cfg_lock = 1'b1;
    wr_reg(2'd0, 32'hFFFF_FFFF);
    wr_reg(2'd1, 32'h0000_2000);
    drive(1, 0, 0, 0, 20);
    drive(0, 0, 0, 0, 20);
    cfg_lock = 1'b0;

    // R10: unused addresses change nothing
    cur_req = "R10";
    wr_reg(2'd2, 32'hFFFF_FFFF);
    wr_reg(2'd3, 32'h0000_0000);
    drive(0, 1, 0, 0, 20);

    // R9: threshold crossings in both directions
    cur_req = "R9";
    wr_reg(2'd0, 32'hFF_00_00_00);
    wr_reg(2'd1, 32'h0000_8000);
    drive(1, 0, 0, 0, 80);
    drive(0, 0, 0, 1, 80);
    wr_reg(2'd1, 32'h0000_0000);
    drive(0, 0, 0, 0, 10);

    // R8: long saturation run and decay to zero
    cur_req = "R8";
    drive(1, 0, 0, 0, 200);
    drive(0, 0, 0, 1, 200);

    finish_up();
  end
endmodule